// File: doc/BRIEF.md
# SPI 24-bit Register Access Master

This block is an SPI master that performs one register access per request on a slave whose registers are 24 bits wide and selected by a 7-bit address. A client places an address, a read/write flag and (for writes) a 24-bit value on the request inputs and raises `req_start` for one cycle while `busy` is low. The block frames the transfer with chip select, sends a command byte followed by three payload bytes, and pulses `done` when chip select is released. After a read, `rd_data` holds the 24 bits returned by the slave.

The command byte is the address in bits 7:1 with the read flag in bit 0. The three payload bytes follow, most significant byte first, and every byte goes out MSB first. On a write the payload is the request data. On a read the master sends 0xFF filler and keeps the three bytes it receives after the command byte. The byte it receives during the command byte is dropped. Writes of zero to command-only slave addresses, such as reset or synchronise strobes, use the same ordinary write frame. The serial clock runs in mode 0. Each SCLK half period lasts `HALF_DIV` system clocks, so a 24 MHz system clock with the default of 4 gives a 3 MHz serial clock.

The controller is a state machine with six states. ST_IDLE waits for a start. ST_SETUP holds chip select low for half a period before the first edge. ST_HIGH and ST_LOW are the two SCLK phases. ST_TAIL holds chip select low for half a period after the last falling edge. ST_GAP keeps chip select high for the deselect time. The transitions are as follows:
- start: ST_IDLE to ST_SETUP.
- first rise: ST_SETUP to ST_HIGH.
- fall: ST_HIGH to ST_LOW, either inside a byte or between bytes.
- rise: ST_LOW to ST_HIGH.
- last bit: ST_HIGH to ST_TAIL, after bit 0 of the fourth byte.
- release: ST_TAIL to ST_GAP.
- rearm: ST_GAP to ST_IDLE.

Top module: `spi24_reg_master`

## Requirements
- R1: A synchronous active-high reset, whether at power-up or mid-frame, leaves `cs_n`=1, `sclk`=0, `busy`=0 and `done`=0 after the clock edge that samples it.
- R2: The first byte of every frame is {addr[6:0], rd}, where rd=1 for a read and rd=0 for a write.
- R3: A write frame holds exactly 32 SCLK rising edges. After the command byte, MOSI carries data bits 23:16, 15:8 and 7:0 in that order, MSB first.
- R4: In a read frame, MOSI is 1 for all 24 bits after the command byte, so each of those bytes is 0xFF.
- R5: In a read, the 8 bits sampled during the command byte are dropped, and the next 24 sampled bits land in `rd_data[23:0]` MSB first. A write frame leaves `rd_data` unchanged.
- R6: Mode 0 applies. `sclk` is low whenever `cs_n` is high. MOSI changes only after falling edges. `cs_n` falls `HALF_DIV` system clocks before the first rising edge of SCLK.
- R7: Each SCLK high phase and each SCLK low phase lasts `HALF_DIV` system clocks.
- R8: `done` is high for exactly one cycle, in the cycle where `cs_n` returns high. `busy` is high from the cycle after a start is accepted through the end of the deselect gap.
- R9: A `req_start` that arrives while `busy` is high starts no frame and does not alter the frame in progress.
- R10: Between two frames, `cs_n` stays high for at least `DESELECT_CYC` system clocks, even when `req_start` is held high.
- R11: A write of all zeros to a command-only address is sent as an ordinary 32-bit write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start request; taken only while idle |
| req_read | input | 1 | 1 = read access, 0 = write access |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write payload |
| busy | output | 1 | A frame or the deselect gap is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| rd_data | output | DATA_W | Result of the most recent read |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |

## Verification
Most internal faults show up at the pins within one frame:
- A wrong byte index or bit count changes how many rising edges fall inside chip select, or which byte appears on MOSI. The slave model catches this when `cs_n` rises.
- A wrong phase timer shows as a SETUP time or SCLK half period other than `HALF_DIV` clocks at the first rising edge.
- A capture that is off by one byte or one bit shows in `rd_data` on the cycle after `done`.
- A controller that leaves the gap early or accepts a start while busy shows as a short deselect interval or an extra chip-select fall during the next few cycles.

// File: rtl/spi24_pkg.sv
package spi24_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] FILL_BYTE = '1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_GAP
    } xfer_state_t;

endpackage

// File: rtl/spi24_phase_timer.sv
module spi24_phase_timer #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CNT_W-1:0] cnt_q;

    // The count restarts whenever a phase ends, so each phase lasts HALF_DIV clocks.
    assign tick = run && (cnt_q == CNT_W'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (HALF_DIV > 1) begin : g_spacing
            // R7
            tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/spi24_byte_shifter.sv
module spi24_byte_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              shift,
    input  logic              sample,
    input  logic              miso,
    output logic              mosi_bit,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              last_bit
);
    localparam int BIT_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] rx_q;
    logic [BIT_W-1:0]  bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= '0;
            rx_q  <= '0;
            bit_q <= '0;
        end else begin
            if (load) begin
                tx_q  <= load_byte;
                bit_q <= '0;
            end else if (shift) begin
                tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                bit_q <= bit_q + 1'b1;
            end
            if (sample) begin
                rx_q <= {rx_q[BYTE_W-2:0], miso};
            end
        end
    end

    assign mosi_bit = tx_q[BYTE_W-1];
    assign rx_byte  = rx_q;
    assign last_bit = (bit_q == BIT_W'(BYTE_W - 1));

    // R3
    always_comb begin
        if (!rst) begin
            load_shift_excl_chk: assert (!(load && shift));
        end
    end

endmodule

// File: rtl/spi24_frame_ctrl.sv
module spi24_frame_ctrl
    import spi24_pkg::*;
#(
    parameter int ADDR_W       = 7,
    parameter int DATA_W       = 24,
    parameter int DESELECT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_start,
    input  logic              req_read,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              tick,
    input  logic              last_bit,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              timer_run,
    output logic              sh_load,
    output logic [BYTE_W-1:0] sh_load_byte,
    output logic              sh_shift,
    output logic              sh_sample,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              sclk,
    output logic              cs_n
);
    localparam int WORD_BYTES  = DATA_W / BYTE_W;
    localparam int FRAME_BYTES = WORD_BYTES + 1;
    localparam int IDX_W       = $clog2(FRAME_BYTES);
    localparam int GAP_W       = (DESELECT_CYC > 1) ? $clog2(DESELECT_CYC + 1) : 1;
    localparam int HI_W        = GAP_W + 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

    xfer_state_t state_q, state_nx;

    logic              rd_q;
    logic [DATA_W-1:0] wdata_q;
    logic [IDX_W-1:0]  idx_q;
    logic [GAP_W-1:0]  gap_q;
    logic [DATA_W-1:0] rd_data_q;
    logic [BYTE_W-1:0] next_byte;
    logic              byte_end;
    logic              cs_n_q, sclk_q, busy_q, done_q;

    // Pick the byte that follows the one just finished.
    always_comb begin
        next_byte = FILL_BYTE;
        if (!rd_q) begin
            for (int k = 0; k < WORD_BYTES; k++) begin
                if (idx_q == IDX_W'(k)) begin
                    next_byte = wdata_q[DATA_W-1-BYTE_W*k -: BYTE_W];
                end
            end
        end
    end

    // Next-state and strobe logic.
    always_comb begin
        state_nx     = state_q;
        sh_load      = 1'b0;
        sh_shift     = 1'b0;
        sh_sample    = 1'b0;
        sh_load_byte = next_byte;
        byte_end     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_start) begin
                    state_nx     = ST_SETUP;
                    sh_load      = 1'b1;
                    sh_load_byte = BYTE_W'({req_addr, req_read});
                end
            end
            ST_SETUP, ST_LOW: begin
                if (tick) begin
                    state_nx  = ST_HIGH;
                    sh_sample = 1'b1;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (last_bit) begin
                        byte_end = 1'b1;
                        if (idx_q == LAST_IDX) begin
                            state_nx = ST_TAIL;
                        end else begin
                            state_nx = ST_LOW;
                            sh_load  = 1'b1;
                        end
                    end else begin
                        state_nx = ST_LOW;
                        sh_shift = 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    state_nx = ST_GAP;
                end
            end
            ST_GAP: begin
                if (gap_q == GAP_W'(DESELECT_CYC - 1)) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign timer_run = (state_q == ST_SETUP) || (state_q == ST_HIGH) ||
                       (state_q == ST_LOW)   || (state_q == ST_TAIL);

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Request latch, byte index, gap count and read capture.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q      <= 1'b0;
            wdata_q   <= '0;
            idx_q     <= '0;
            gap_q     <= '0;
            rd_data_q <= '0;
        end else begin
            if (state_q == ST_IDLE && req_start) begin
                rd_q    <= req_read;
                wdata_q <= req_wdata;
                idx_q   <= '0;
            end else if (byte_end) begin
                idx_q <= idx_q + 1'b1;
                if (rd_q && idx_q != '0) begin
                    rd_data_q <= {rd_data_q[DATA_W-BYTE_W-1:0], rx_byte};
                end
            end
            if (state_q == ST_GAP) begin
                gap_q <= gap_q + 1'b1;
            end else begin
                gap_q <= '0;
            end
        end
    end

    // Registered pin outputs, aligned with the state register.
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n_q <= 1'b1;
            sclk_q <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            cs_n_q <= !((state_nx == ST_SETUP) || (state_nx == ST_HIGH) ||
                        (state_nx == ST_LOW)   || (state_nx == ST_TAIL));
            sclk_q <= (state_nx == ST_HIGH);
            busy_q <= (state_nx != ST_IDLE);
            done_q <= (state_q == ST_TAIL) && tick;
        end
    end

    assign cs_n    = cs_n_q;
    assign sclk    = sclk_q;
    assign busy    = busy_q;
    assign done    = done_q;
    assign rd_data = rd_data_q;

    // Count of consecutive deselected cycles, used only by the gap check.
    logic [HI_W-1:0] hi_cnt_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt_q <= HI_W'(DESELECT_CYC);
        end else if (cs_n_q) begin
            if (hi_cnt_q < HI_W'(DESELECT_CYC)) begin
                hi_cnt_q <= hi_cnt_q + 1'b1;
            end
        end else begin
            hi_cnt_q <= '0;
        end
    end

    logic rst_d_q;
    always_ff @(posedge clk) begin
        rst_d_q <= rst;
    end

    // R1
    always_comb begin
        if (rst_d_q) begin
            reset_idle_chk: assert (cs_n_q && !sclk_q && !busy_q && !done_q);
        end
    end

    // R6
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_q |-> !sclk_q);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R8
    done_release_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $rose(cs_n_q));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && req_start) |=> ($stable(wdata_q) && $stable(rd_q)));

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_q || !rd_q) |=> $stable(rd_data_q));

    // R10
    deselect_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_q) |-> (hi_cnt_q >= HI_W'(DESELECT_CYC)));

endmodule

// File: rtl/spi24_reg_master.sv
module spi24_reg_master
    import spi24_pkg::*;
#(
    parameter int HALF_DIV     = 4,
    parameter int ADDR_W       = 7,
    parameter int DATA_W       = 24,
    parameter int DESELECT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_start,
    input  logic              req_read,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    logic              timer_run;
    logic              tick;
    logic              sh_load;
    logic [BYTE_W-1:0] sh_load_byte;
    logic              sh_shift;
    logic              sh_sample;
    logic              sh_mosi;
    logic [BYTE_W-1:0] rx_byte;
    logic              last_bit;

    spi24_phase_timer #(
        .HALF_DIV(HALF_DIV)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (timer_run),
        .tick (tick)
    );

    spi24_byte_shifter #(
        .BYTE_W(BYTE_W)
    ) u_shifter (
        .clk       (clk),
        .rst       (rst),
        .load      (sh_load),
        .load_byte (sh_load_byte),
        .shift     (sh_shift),
        .sample    (sh_sample),
        .miso      (miso),
        .mosi_bit  (sh_mosi),
        .rx_byte   (rx_byte),
        .last_bit  (last_bit)
    );

    spi24_frame_ctrl #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .DESELECT_CYC (DESELECT_CYC)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_start    (req_start),
        .req_read     (req_read),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .tick         (tick),
        .last_bit     (last_bit),
        .rx_byte      (rx_byte),
        .timer_run    (timer_run),
        .sh_load      (sh_load),
        .sh_load_byte (sh_load_byte),
        .sh_shift     (sh_shift),
        .sh_sample    (sh_sample),
        .busy         (busy),
        .done         (done),
        .rd_data      (rd_data),
        .sclk         (sclk),
        .cs_n         (cs_n)
    );

    assign mosi = sh_mosi & ~cs_n;

endmodule

// File: tb/spi24_reg_master_bench.sv
module spi24_reg_master_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int DES        = 2;

    // Vector layout: {rd, addr[6:0], wdata[23:0], slave reply[23:0]}
    localparam int NVEC = 6;
    localparam logic [55:0] VEC [NVEC] = '{
        {1'b0, 7'h10, 24'hABCDEF, 24'h123456},
        {1'b1, 7'h0F, 24'h000000, 24'hC3A55A},
        {1'b0, 7'h08, 24'h000000, 24'hFFFFFF},
        {1'b1, 7'h7F, 24'h000000, 24'h800001},
        {1'b1, 7'h00, 24'hFFFFFF, 24'h000000},
        {1'b0, 7'h55, 24'h5AA5F0, 24'h0F0F0F}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_start, req_read;
    logic [6:0]  req_addr;
    logic [23:0] req_wdata;
    logic        busy, done, sclk, cs_n, mosi, miso;
    logic [23:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit reported = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi24_reg_master #(
        .HALF_DIV(HALF), .ADDR_W(7), .DATA_W(24), .DESELECT_CYC(DES)
    ) u_spi24_reg_master (
        .clk(clk), .rst(rst), .req_start(req_start), .req_read(req_read),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    // Slave model: presents a bit at chip-select fall, advances on each falling SCLK.
    logic [31:0] slv_reply = 32'h0;
    int slv_idx = 0;
    always @(posedge cs_n or negedge sclk) begin
        if (cs_n) slv_idx <= 0;
        else      slv_idx <= slv_idx + 1;
    end
    assign miso = (!cs_n && slv_idx < 32) ? slv_reply[31 - slv_idx] : 1'b0;

    // MOSI capture on rising SCLK, cleared at chip-select fall.
    logic [31:0] cap = 32'h0;
    int cap_n = 0;
    int frames = 0;
    always @(negedge cs_n or posedge sclk) begin
        if (sclk) begin
            cap   <= {cap[30:0], mosi};
            cap_n <= cap_n + 1;
        end else begin
            cap   <= 32'h0;
            cap_n <= 0;
        end
    end
    always @(negedge cs_n) frames <= frames + 1;

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic run_frame(input logic rd, input logic [6:0] addr, input logic [23:0] wd);
        @(negedge clk);
        req_start = 1'b1; req_read = rd; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_start = 1'b0;
        check(busy == 1'b1, "R8 busy after accept", {31'h0, busy}, 32'h1);
        wait_done();
        check(cs_n == 1'b1, "R8 cs_n high with done", {31'h0, cs_n}, 32'h1);
        check(busy == 1'b1, "R8 busy through gap", {31'h0, busy}, 32'h1);
        @(negedge clk);
        check(done == 1'b0, "R8 done single cycle", {31'h0, done}, 32'h0);
        while (busy) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        report();
        $finish;
    end

    initial begin
        logic [23:0] prev_rd;
        int cnt;
        rst = 1'b1; req_start = 1'b0; req_read = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0 && done == 1'b0,
              "R1 reset outputs", {28'h0, cs_n, sclk, busy, done}, 32'h8);
        rst = 1'b0;
        @(negedge clk);
        check(rd_data == 24'h0, "R1 rd_data after reset", {8'h0, rd_data}, 32'h0);
        prev_rd = 24'h0;

        // Table walk: R2, R3, R4, R5, R11
        for (int i = 0; i < NVEC; i++) begin
            logic        v_rd;
            logic [6:0]  v_addr;
            logic [23:0] v_wd, v_rep;
            logic [31:0] exp_cap;
            {v_rd, v_addr, v_wd, v_rep} = VEC[i];
            slv_reply = {8'h5A, v_rep};
            exp_cap = {v_addr, v_rd, (v_rd ? 24'hFFFFFF : v_wd)};
            run_frame(v_rd, v_addr, v_wd);
            check(cap[31:24] == {v_addr, v_rd}, "R2 command byte", {24'h0, cap[31:24]}, {24'h0, v_addr, v_rd});
            check(cap_n == 32, "R3 bit count", cap_n, 32);
            if (v_rd) begin
                check(cap == exp_cap, "R4 read fill bytes", cap, exp_cap);
                check(rd_data == v_rep, "R5 read capture", {8'h0, rd_data}, {8'h0, v_rep});
                prev_rd = v_rep;
            end else begin
                check(cap == exp_cap, (v_wd == 24'h0) ? "R11 zero write frame" : "R3 write payload", cap, exp_cap);
                check(rd_data == prev_rd, "R5 write keeps rd_data", {8'h0, rd_data}, {8'h0, prev_rd});
            end
        end

        // R6 / R7 timing of chip select setup and SCLK phases
        @(negedge clk);
        req_start = 1'b1; req_read = 1'b0; req_addr = 7'h33; req_wdata = 24'h00FF00;
        @(negedge clk);
        req_start = 1'b0;
        while (cs_n) @(negedge clk);
        cnt = 0;
        while (!sclk && cnt < 100) begin cnt++; @(negedge clk); end
        check(cnt == HALF, "R6 cs_n setup before first rise", cnt, HALF);
        cnt = 0;
        while (sclk && cnt < 100) begin cnt++; @(negedge clk); end
        check(cnt == HALF, "R7 sclk high phase", cnt, HALF);
        cnt = 0;
        while (!sclk && cnt < 100) begin cnt++; @(negedge clk); end
        check(cnt == HALF, "R7 sclk low phase", cnt, HALF);
        wait_done();
        while (busy) @(negedge clk);
        check(cap == {7'h33, 1'b0, 24'h00FF00}, "R6 mode 0 data", cap, {7'h33, 1'b0, 24'h00FF00});

        // R9 start while busy is ignored
        begin
            int f0;
            f0 = frames;
            @(negedge clk);
            req_start = 1'b1; req_read = 1'b0; req_addr = 7'h11; req_wdata = 24'h0F0F0F;
            @(negedge clk);
            req_start = 1'b0;
            repeat (20) @(negedge clk);
            req_start = 1'b1; req_read = 1'b1; req_addr = 7'h7F;
            @(negedge clk);
            req_start = 1'b0;
            wait_done();
            repeat (8) @(negedge clk);
            check(frames == f0 + 1, "R9 no extra frame", frames, f0 + 1);
            check(cap == {7'h11, 1'b0, 24'h0F0F0F}, "R9 frame unchanged", cap, {7'h11, 1'b0, 24'h0F0F0F});
        end

        // R10 deselect gap with start held high
        @(negedge clk);
        req_start = 1'b1; req_read = 1'b0; req_addr = 7'h01; req_wdata = 24'h111111;
        @(negedge clk);
        wait_done();
        cnt = 0;
        while (cs_n && cnt < 100) begin cnt++; @(negedge clk); end
        req_start = 1'b0;
        check(cnt >= DES, "R10 deselect interval", cnt, DES);
        wait_done();
        while (busy) @(negedge clk);
        check(cap == {7'h01, 1'b0, 24'h111111}, "R10 second frame", cap, {7'h01, 1'b0, 24'h111111});

        // R1 mid-frame reset
        @(negedge clk);
        req_start = 1'b1; req_read = 1'b1; req_addr = 7'h22;
        @(negedge clk);
        req_start = 1'b0;
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0 && done == 1'b0,
              "R1 mid-frame reset", {28'h0, cs_n, sclk, busy, done}, 32'h8);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(cs_n == 1'b1, "R1 stays idle after reset", {31'h0, cs_n}, 32'h1);

        report();
        $finish;
    end

endmodule